// File: doc/BRIEF.md
# Strobed Request/Acknowledge Controller with Holding Registers

This block is a small synchronous controller built to keep its outputs free of decoder transients and its state register free of multi-bit races. It runs on one fast clock and derives three one-cycle enables from an internal 2-bit phase counter. The controller steps its state once every four fast cycles. Two asynchronous inputs, `req_async` and `done_async`, are captured into an input holding register on a sync strobe that runs two or four times faster than the state rate. Only the held copies reach the next-state logic. The decoded outputs are not driven straight to the ports. They pass through an output holding register that loads two fast cycles after each state update, once the decode has settled.

The example controller is a four-state handshake sequencer. It leaves its idle state on a held request and passes through an arming step into a busy state. It waits there for a held completion, then raises an acknowledge for one controller step and returns to idle. The state codes follow a Johnson sequence, so every transition flips exactly one flip-flop, including the branches that depend on an asynchronous input.

Top module: `glitch_safe_ctrl`

## Requirements
- R1: While `rst_n` is low, `ack` and `busy` are 0. After `rst_n` rises, the internal logic leaves reset on the second rising clock edge, with phase 0, the idle state and both holding registers cleared.
- R2: The input holding register captures bit 0 = request and bit 1 = completion only on sync-strobe edges. With `SYNC_RATIO`=4 the strobe fires every phase. With `SYNC_RATIO`=2 it fires on phases 0 and 2 only. Between strobes the held value does not change.
- R3: The phase counter counts 0,1,2,3 and wraps. The state register updates only on phase-0 edges. The codes are idle=00, arm=01, busy=11, ack=10, and each update changes exactly one bit.
- R4: Idle goes to arm when the held request is 1 and otherwise stays idle. Arm always goes to busy. Busy goes to ack when the held completion is 1 and otherwise stays busy. Ack always returns to idle.
- R5: The decoded `busy` is 1 in arm and busy. The decoded `ack` is 1 only in ack.
- R6: The output holding register loads only on phase-2 edges, so `ack` and `busy` change only in the cycle where the phase reads 3.
- R7: An output that the decode keeps at 1 stays continuously high at the port across consecutive state updates. `busy` stays high from arm through every busy step.
- R8: Each state's branch depends on at most one input. Completion has no effect in idle. Request has no effect in arm, busy and ack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, four times the controller step rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_async | input | 1 | Asynchronous start request |
| done_async | input | 1 | Asynchronous completion indication |
| ack | output | 1 | Registered acknowledge, high for the ack state |
| busy | output | 1 | Registered busy, high during arm and busy |

## Verification
The hardest case to reach is an input pulse of one fast cycle that one strobe ratio captures and the other misses. This depends on the exact phase at which the pulse lands. The bench runs a 2x and a 4x instance side by side and tracks the phase from the release of reset. It places one pulse on phase 2, which only the 2x instance captures, and another on phase 3, which only the 4x instance captures. Randomized request and completion timing is compared cycle by cycle against a reference model, and every port change is checked to fall in the phase-3 cycle.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

  // Johnson-ordered controller state: neighbours differ in one bit
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ARM  = 2'b01,
    ST_BUSY = 2'b11,
    ST_ACK  = 2'b10
  } ctl_state_t;

  localparam int PHASE_W   = 2;
  localparam int PH_UPDATE = 0;
  localparam int PH_OUTPUT = 2;

  // input holding register bit positions
  localparam int N_ASYNC  = 2;
  localparam int IDX_REQ  = 0;
  localparam int IDX_DONE = 1;

  // output holding register bit positions
  localparam int N_OUT    = 2;
  localparam int OUT_BUSY = 0;
  localparam int OUT_ACK  = 1;

endpackage

// File: rtl/gsc_phase_gen.sv
module gsc_phase_gen
  import gsc_pkg::*;
#(
  parameter int SYNC_RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic upd_en,
  output logic sync_stb,
  output logic out_stb
);

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_d;

  always_comb begin
    phase_d = phase_q + {{(PHASE_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign upd_en  = (phase_q == PHASE_W'(PH_UPDATE));
  assign out_stb = (phase_q == PHASE_W'(PH_OUTPUT));

  generate
    if (SYNC_RATIO == 4) begin : g_sync_x4
      assign sync_stb = 1'b1;
    end else begin : g_sync_x2
      assign sync_stb = ~phase_q[0];
    end
  endgenerate

  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> phase_q == $past(phase_q) + 2'd1); // R3

  AST_OUT_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && out_stb) |-> $past(upd_en, 2)); // R6

endmodule

// File: rtl/gsc_hold_reg.sv
module gsc_hold_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] hold_q;
  logic [W-1:0] hold_d;

  always_comb begin
    hold_d = ld ? d : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign q = hold_q;

  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ld)) |-> q == $past(q)); // R2 R6

endmodule

// File: rtl/gsc_seq_core.sv
module gsc_seq_core
  import gsc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_en,
  input  logic [N_ASYNC-1:0] in_held,
  output logic [N_OUT-1:0]   out_dec
);

  ctl_state_t state_q;
  ctl_state_t state_d;
  ctl_state_t state_nxt;
  logic       req_h;
  logic       done_h;

  assign req_h  = in_held[IDX_REQ];
  assign done_h = in_held[IDX_DONE];

  // each branch looks at a single held input
  always_comb begin
    state_nxt = state_q;
    case (state_q)
      ST_IDLE: state_nxt = req_h  ? ST_ARM : ST_IDLE;
      ST_ARM:  state_nxt = ST_BUSY;
      ST_BUSY: state_nxt = done_h ? ST_ACK : ST_BUSY;
      ST_ACK:  state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    state_d = upd_en ? state_nxt : state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    out_dec           = '0;
    out_dec[OUT_BUSY] = (state_q == ST_ARM) || (state_q == ST_BUSY);
    out_dec[OUT_ACK]  = (state_q == ST_ACK);
  end

  logic [1:0] st_bits;
  assign st_bits = state_q;

  AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && st_bits != $past(st_bits)) |->
      $countones(st_bits ^ $past(st_bits)) == 1); // R3

  AST_STATE_ON_UPDATE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(upd_en)) |-> $stable(st_bits)); // R3

  AST_ARM_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARM && upd_en) |=> state_q == ST_BUSY); // R4

  AST_IDLE_IGNORES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && upd_en && !req_h) |=> state_q == ST_IDLE); // R8

  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY && upd_en && !done_h) |=> state_q == ST_BUSY); // R8

endmodule

// File: rtl/glitch_safe_ctrl.sv
module glitch_safe_ctrl
  import gsc_pkg::*;
#(
  parameter int SYNC_RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  input  logic done_async,
  output logic ack,
  output logic busy
);

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  logic upd_en;
  logic sync_stb;
  logic out_stb;

  gsc_phase_gen #(.SYNC_RATIO(SYNC_RATIO)) u_phase (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .upd_en   (upd_en),
    .sync_stb (sync_stb),
    .out_stb  (out_stb)
  );

  logic [N_ASYNC-1:0] in_raw;
  logic [N_ASYNC-1:0] in_held;

  always_comb begin
    in_raw           = '0;
    in_raw[IDX_REQ]  = req_async;
    in_raw[IDX_DONE] = done_async;
  end

  gsc_hold_reg #(.W(N_ASYNC)) u_in_hold (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ld    (sync_stb),
    .d     (in_raw),
    .q     (in_held)
  );

  logic [N_OUT-1:0] out_dec;
  logic [N_OUT-1:0] out_held;

  gsc_seq_core u_core (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .upd_en  (upd_en),
    .in_held (in_held),
    .out_dec (out_dec)
  );

  gsc_hold_reg #(.W(N_OUT)) u_out_hold (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ld    (out_stb),
    .d     (out_dec),
    .q     (out_held)
  );

  assign ack  = out_held[OUT_ACK];
  assign busy = out_held[OUT_BUSY];

  AST_PORTS_ONLY_AFTER_OUT_STB: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(rst_int_n) && !$past(out_stb)) |-> ($stable(ack) && $stable(busy))); // R6

  AST_RESET_OUTPUTS_LOW: assert property (@(posedge clk)
    !rst_n |-> (!ack && !busy)); // R1

endmodule

// File: tb/test_glitch_safe_ctrl.sv
module gsc_ref_model #(
  parameter int RATIO = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       done,
  output logic       ack,
  output logic       busy,
  output logic [1:0] ph
);
  // states numbered 0 idle, 1 arm, 2 busy, 3 ack
  logic [1:0] rs;
  int         st;
  logic       rq_h;
  logic       dn_h;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs <= 2'b00; ph <= 2'd0; st <= 0; rq_h <= 1'b0; dn_h <= 1'b0;
      ack <= 1'b0; busy <= 1'b0;
    end else begin
      rs <= {rs[0], 1'b1};
      if (rs[1]) begin
        ph <= ph + 2'd1;
        if (RATIO == 4 || ph[0] == 1'b0) begin
          rq_h <= req;
          dn_h <= done;
        end
        if (ph == 2'd0) begin
          case (st)
            0: if (rq_h) st <= 1;
            1: st <= 2;
            2: if (dn_h) st <= 3;
            default: st <= 0;
          endcase
        end
        if (ph == 2'd2) begin
          busy <= (st == 1) || (st == 2);
          ack  <= (st == 3);
        end
      end
    end
  end
endmodule

module test_glitch_safe_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic done = 1'b0;
  logic ack4, busy4, ack2, busy2;
  logic m_ack4, m_busy4, m_ack2, m_busy2;
  logic [1:0] ph4, ph2;
  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  logic prev_ack4 = 1'b0, prev_busy4 = 1'b0;

  always #10 clk = ~clk;

  glitch_safe_ctrl #(.SYNC_RATIO(4)) i_glitch_safe_ctrl (
    .clk(clk), .rst_n(rst_n), .req_async(req), .done_async(done),
    .ack(ack4), .busy(busy4));

  glitch_safe_ctrl #(.SYNC_RATIO(2)) i_glitch_safe_ctrl_x2 (
    .clk(clk), .rst_n(rst_n), .req_async(req), .done_async(done),
    .ack(ack2), .busy(busy2));

  gsc_ref_model #(.RATIO(4)) i_ref4 (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done),
    .ack(m_ack4), .busy(m_busy4), .ph(ph4));

  gsc_ref_model #(.RATIO(2)) i_ref2 (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done),
    .ack(m_ack2), .busy(m_busy2), .ph(ph2));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", rq, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(1'b0, "watchdog", cyc, 0);
      summary();
      $finish;
    end
  end

  // cycle-by-cycle comparison against the reference model
  always @(negedge clk) begin
    if (mon_en) begin
      chk({ack4, busy4} == {m_ack4, m_busy4}, "R4 R5 x4", {ack4, busy4}, {m_ack4, m_busy4});
      chk({ack2, busy2} == {m_ack2, m_busy2}, "R2 R5 x2", {ack2, busy2}, {m_ack2, m_busy2});
      if (ack4 != prev_ack4 || busy4 != prev_busy4)
        chk(ph4 == 2'd3, "R6 change phase", ph4, 3);
    end
    prev_ack4  = ack4;
    prev_busy4 = busy4;
  end

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle_cycles(4);
    chk({ack4, busy4, ack2, busy2} == 4'b0, "R1 in reset", {ack4, busy4, ack2, busy2}, 0);
    rst_n = 1'b1;
    idle_cycles(2);
    chk(ph4 == 2'd0, "R1 release phase", ph4, 0);
    idle_cycles(6);
    chk({ack4, busy4, ack2, busy2} == 4'b0, "R1 after release", {ack4, busy4, ack2, busy2}, 0);
    mon_en = 1'b1;
  endtask

  task automatic t_handshake();
    int waited = 0;
    int hi = 0;
    req = 1'b1;
    while (!busy4 && waited < 40) begin @(negedge clk); waited++; end
    chk(busy4 == 1'b1, "R4 idle to arm", busy4, 1);
    req = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy4 && !ack4) hi++;
    end
    chk(hi == 20, "R7 busy held across updates", hi, 20);
    done = 1'b1;
    waited = 0;
    while (!ack4 && waited < 40) begin @(negedge clk); waited++; end
    chk(ack4 == 1'b1 && busy4 == 1'b0, "R5 ack decode", {ack4, busy4}, 2);
    done = 1'b0;
    idle_cycles(12);
    chk({ack4, busy4} == 2'b00, "R4 ack to idle", {ack4, busy4}, 0);
  endtask

  task automatic wait_phase(input logic [1:0] p);
    do @(negedge clk); while (ph4 != p);
  endtask

  task automatic drain();
    done = 1'b1;
    idle_cycles(16);
    done = 1'b0;
    idle_cycles(12);
  endtask

  task automatic t_strobe_ratio();
    wait_phase(2'd2);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    idle_cycles(12);
    chk(busy2 == 1'b1, "R2 x2 captures phase-2 pulse", busy2, 1);
    chk(busy4 == 1'b0, "R2 x4 drops phase-2 pulse", busy4, 0);
    drain();
    chk({ack2, busy2} == 2'b00, "R4 x2 back to idle", {ack2, busy2}, 0);
    wait_phase(2'd3);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    idle_cycles(12);
    chk(busy4 == 1'b1, "R2 x4 captures phase-3 pulse", busy4, 1);
    chk(busy2 == 1'b0, "R2 x2 drops phase-3 pulse", busy2, 0);
    drain();
  endtask

  task automatic t_ignored();
    done = 1'b1;
    idle_cycles(16);
    chk({ack4, busy4} == 2'b00, "R8 done ignored in idle", {ack4, busy4}, 0);
    done = 1'b0;
    req = 1'b1;
    idle_cycles(16);
    chk({ack4, busy4} == 2'b01, "R8 req ignored in busy", {ack4, busy4}, 1);
    idle_cycles(16);
    chk({ack4, busy4} == 2'b01, "R8 still busy with req high", {ack4, busy4}, 1);
    req = 1'b0;
    drain();
    chk({ack4, busy4} == 2'b00, "R4 idle after done", {ack4, busy4}, 0);
  endtask

  task automatic t_random();
    for (int n = 0; n < 60; n++) begin
      idle_cycles(($urandom % 9) + 1);
      req = 1'b1;
      idle_cycles(($urandom % 6) + 1);
      req = 1'b0;
      idle_cycles(($urandom % 20) + 1);
      done = 1'b1;
      idle_cycles(($urandom % 5) + 1);
      done = 1'b0;
    end
    drain();
    chk({ack4, busy4, ack2, busy2} == 4'b0, "R4 random run ends idle",
        {ack4, busy4, ack2, busy2}, 0);
  endtask

  initial begin
    t_reset();
    t_handshake();
    t_strobe_ratio();
    t_ignored();
    t_random();
    summary();
    $finish;
  end
endmodule